// File: doc/BRIEF.md
# NCO Digital Up-Conversion Mixer

This block shifts a baseband sample stream up in frequency ahead of a converter. A 32-bit phase accumulator advances by a programmable step every clock. The top ten bits of the accumulator address a sine/cosine table that stores one quarter of a wave. The resulting cosine and sine multiply the incoming I and Q samples, and each sum of products is rounded and saturated back to 16 bits. The output frequency is the step word times the clock rate divided by 2^32. A step read as two's complement gives a negative frequency.

Three mixing arrangements are selectable. The first takes a complex input and produces one real output. The second adds a second product pair so that the output is itself an I/Q pair. The third treats the two inputs as independent real channels at half the clock rate. In that arrangement the sine term is zero and each channel is only multiplied by an alternating sign. A phase-clear input puts the accumulator back to zero so that several devices can be brought into phase alignment.

Top module: `nco_mixer`

## Requirements
- R1: While rstN is low, and on the first cycle after it rises, outI and outQ are 0 and the phase accumulator holds 0.
- R2: On every clock without phaseClr, and outside the half-rate mode, the accumulator adds freqWord modulo 2^32. A new freqWord is used at the very next clock edge. Words of 2^31 and above act as negative frequencies.
- R3: When phaseClr is high at a clock edge, the accumulator becomes 0 at that edge, whatever freqWord is.
- R4: The table is addressed by accumulator bits [31:22]. Address 0 gives cosine +32767 and sine 0. Address 256 gives cosine 0 and sine +32767. Address 512 gives cosine -32767 and sine 0. Address 768 gives cosine 0 and sine -32767.
- R5: mixMode 2'b00 (complex in, real out) gives outI = I*cos - Q*sin and outQ = 0. Code 2'b11 behaves the same way.
- R6: mixMode 2'b01 (complex in, complex out) gives outI = I*cos - Q*sin and outQ = I*sin + Q*cos.
- R7: In mixMode 2'b10 (two real channels), the accumulator steps by 2^31 and freqWord is ignored. outI = s*I and outQ = s*Q. The sign s is +1 for the sample taken on the first edge after a clear, and it alternates on every later edge.
- R8: In the product modes, each sum of products is scaled by 2^-15 as floor((sum + 2^14) / 2^15), then clamped to [-32768, 32767]. Negating -32768 in the half-rate mode gives 32767.
- R9: A sample, the mode and the accumulator value present at edge k are combined into an output that appears after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous reset, active low |
| freqWord | input | 32 | Phase step per clock (two's complement) |
| phaseClr | input | 1 | Clears the phase accumulator at the next edge |
| mixMode | input | 2 | 00/11 complex-to-real, 01 complex-to-complex, 10 two real channels |
| sampleI | input | 16 | Signed I (or channel A) sample |
| sampleQ | input | 16 | Signed Q (or channel B) sample |
| outI | output | 16 | Signed mixed output, real or I |
| outQ | output | 16 | Signed mixed output, Q or channel B |

## Verification
A phase clear takes effect at the edge where it is sampled. The accumulator value on the next edge is then registered together with the sample, and the mixed result appears one edge later. So the output for phase zero is read two edges after the clear.

To present an arbitrary phase, the bench clears the accumulator, applies the wanted phase as the step for one edge, and then holds the step at zero. It reads the output three edges after the clear. When the step is held constant, each later phase is read on each following cycle.

All reads happen on the falling clock edge. Expected values come from the quarter-point table values, where cosine and sine are exact, and from the rounding and clamping formula.

// File: rtl/nco_mix_pkg.sv
`timescale 1ns/1ps
package nco_mix_pkg;

  localparam int PHASE_W  = 32;
  localparam int LUT_AW   = 10;
  localparam int SAMPLE_W = 16;
  localparam int FRAC_W   = SAMPLE_W - 1;
  localparam int PROD_W   = 2 * SAMPLE_W;
  localparam int SUM_W    = PROD_W + 1;

  typedef enum logic [1:0] {
    MIX_TO_REAL   = 2'b00,
    MIX_TO_IQ     = 2'b01,
    MIX_DUAL_HALF = 2'b10,
    MIX_SPARE     = 2'b11
  } mixMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [LUT_AW-1:0] phaseIdx;
    logic              iqOut;
    logic              dualReal;
    logic              flipSign;
  } mixCtl_t;

  localparam logic signed [SUM_W:0] ROUND_BIAS = (SUM_W+1)'(1) <<< (FRAC_W - 1);
  localparam logic signed [SUM_W:0] SAT_HI = (SUM_W+1)'((1 <<< (SAMPLE_W-1)) - 1);
  localparam logic signed [SUM_W:0] SAT_LO = -((SUM_W+1)'(1) <<< (SAMPLE_W-1));

  // scale a product sum back to sample width with half-up rounding and clamp
  function automatic logic signed [SAMPLE_W-1:0] roundSat(input logic signed [SUM_W-1:0] s);
    logic signed [SUM_W:0] biased;
    logic signed [SUM_W:0] shifted;
    biased  = (SUM_W+1)'(s) + ROUND_BIAS;
    shifted = biased >>> FRAC_W;
    if (shifted > SAT_HI)      roundSat = SAT_HI[SAMPLE_W-1:0];
    else if (shifted < SAT_LO) roundSat = SAT_LO[SAMPLE_W-1:0];
    else                       roundSat = shifted[SAMPLE_W-1:0];
  endfunction

  // clamp a one-bit-wider value to sample width
  function automatic logic signed [SAMPLE_W-1:0] clampWide(input logic signed [SAMPLE_W:0] v);
    logic signed [SAMPLE_W:0] hi;
    logic signed [SAMPLE_W:0] lo;
    hi = (SAMPLE_W+1)'((1 <<< (SAMPLE_W-1)) - 1);
    lo = -((SAMPLE_W+1)'(1) <<< (SAMPLE_W-1));
    if (v > hi)      clampWide = hi[SAMPLE_W-1:0];
    else if (v < lo) clampWide = lo[SAMPLE_W-1:0];
    else             clampWide = v[SAMPLE_W-1:0];
  endfunction

endpackage

// File: rtl/nco_sincos_lut.sv
`timescale 1ns/1ps
module nco_sincos_lut #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic [AW-1:0]        idx,
  output logic signed [DW-1:0] sinVal,
  output logic signed [DW-1:0] cosVal
);

  localparam int QN      = 1 << (AW - 2);
  localparam int QW      = AW - 2;
  localparam int FRAC    = 28;
  localparam longint AMP = (64'sd1 <<< (DW - 1)) - 1;
  localparam longint PI_Q = 64'sd843314857;   // pi scaled by 2^28

  // sine of k quarter-steps, scaled to AMP, by a fixed-point series
  function automatic longint quarterSine(input int k);
    longint x;
    longint x2;
    longint term;
    longint acc;
    longint r;
    x    = (longint'(k) * PI_Q) / (2 * QN);
    x2   = (x * x) >>> FRAC;
    term = x;
    acc  = x;
    for (int n = 1; n <= 7; n++) begin
      term = -(((term * x2) >>> FRAC) / longint'((2 * n) * (2 * n + 1)));
      acc  = acc + term;
    end
    r = (acc * AMP + (64'sd1 <<< (FRAC - 1))) >>> FRAC;
    if (r > AMP) r = AMP;
    if (r < 0)   r = 0;
    return r;
  endfunction

  logic signed [DW-1:0] quarter [QN+1];

  for (genvar k = 0; k <= QN; k++) begin : g_fill
    localparam longint ENTRY = quarterSine(k);
    assign quarter[k] = DW'(ENTRY);
  end

  logic signed [DW-1:0] lookVal [2];

  // port 0 is sine, port 1 reads a quarter turn ahead to give cosine
  for (genvar g = 0; g < 2; g++) begin : g_port
    logic [AW-1:0]    portIdx;
    logic [1:0]       quad;
    logic [QW-1:0]    offs;
    logic [AW-2:0]    addr;
    logic signed [DW-1:0] mag;

    assign portIdx = idx + AW'(g * QN);
    assign quad    = portIdx[AW-1:AW-2];
    assign offs    = portIdx[QW-1:0];
    assign addr    = quad[0] ? ((AW-1)'(QN) - {1'b0, offs}) : {1'b0, offs};
    assign mag     = quarter[addr];
    assign lookVal[g] = quad[1] ? -mag : mag;
  end

  assign sinVal = lookVal[0];
  assign cosVal = lookVal[1];

endmodule

// File: rtl/nco_mix_ctrl.sv
`timescale 1ns/1ps
module nco_mix_ctrl
  import nco_mix_pkg::*;
#(
  parameter int PW = PHASE_W,
  parameter int AW = LUT_AW
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [PW-1:0] freqWord,
  input  logic          phaseClr,
  input  logic [1:0]    mixMode,
  output mixCtl_t       ctl
);

  localparam logic [PW-1:0] HALF_STEP = PW'(1) << (PW - 1);

  mixMode_e      modeSel;
  logic          isDual;
  logic [PW-1:0] phaseStep;
  logic [PW-1:0] phaseAcc;

  assign modeSel   = mixMode_e'(mixMode);
  assign isDual    = (modeSel == MIX_DUAL_HALF);
  assign phaseStep = isDual ? HALF_STEP : freqWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         phaseAcc <= '0;
    else if (phaseClr) phaseAcc <= '0;
    else               phaseAcc <= phaseAcc + phaseStep;
  end

  always_comb begin
    ctl.phaseIdx = phaseAcc[PW-1 -: AW];
    ctl.iqOut    = (modeSel == MIX_TO_IQ);
    ctl.dualReal = isDual;
    ctl.flipSign = phaseAcc[PW-1];
  end

  // R2
  freq_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!phaseClr && !isDual) |=> (phaseAcc == $past(phaseAcc) + $past(freqWord)));

  // R3
  phase_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    phaseClr |=> (phaseAcc == '0));

  // R7
  half_rate_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isDual && !phaseClr) |=> (phaseAcc[PW-1] != $past(phaseAcc[PW-1])));

endmodule

// File: rtl/nco_mix_datapath.sv
`timescale 1ns/1ps
module nco_mix_datapath
  import nco_mix_pkg::*;
#(
  parameter int DW = SAMPLE_W,
  parameter int AW = LUT_AW
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mixCtl_t              ctl,
  input  logic signed [DW-1:0] sampleI,
  input  logic signed [DW-1:0] sampleQ,
  output logic signed [DW-1:0] outI,
  output logic signed [DW-1:0] outQ
);

  localparam int PW2 = 2 * DW;
  localparam int SW  = PW2 + 1;
  localparam logic signed [DW-1:0] FULL = DW'((1 <<< (DW - 1)) - 1);

  logic signed [DW-1:0] sinNow;
  logic signed [DW-1:0] cosNow;

  nco_sincos_lut #(.AW(AW), .DW(DW)) u_lut (
    .idx    (ctl.phaseIdx),
    .sinVal (sinNow),
    .cosVal (cosNow)
  );

  // stage 1: sample, oscillator value and strobes aligned
  logic signed [DW-1:0] iR, qR, cosR, sinR;
  logic                 iqR, dualR, flipR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iR <= '0; qR <= '0; cosR <= '0; sinR <= '0;
      iqR <= 1'b0; dualR <= 1'b0; flipR <= 1'b0;
    end else begin
      iR    <= sampleI;
      qR    <= sampleQ;
      cosR  <= cosNow;
      sinR  <= sinNow;
      iqR   <= ctl.iqOut;
      dualR <= ctl.dualReal;
      flipR <= ctl.flipSign;
    end
  end

  // stage 2: products, sums, rounding and clamping
  logic signed [PW2-1:0] pIc, pQs, pIs, pQc;
  logic signed [SW-1:0]  sumRe, sumIm;
  logic signed [DW:0]    wideI, wideQ;
  logic signed [DW-1:0]  nextI, nextQ;

  always_comb begin
    pIc   = iR * cosR;
    pQs   = qR * sinR;
    pIs   = iR * sinR;
    pQc   = qR * cosR;
    sumRe = SW'(pIc) - SW'(pQs);
    sumIm = SW'(pIs) + SW'(pQc);
    wideI = flipR ? -((DW+1)'(iR)) : (DW+1)'(iR);
    wideQ = flipR ? -((DW+1)'(qR)) : (DW+1)'(qR);
    if (dualR) begin
      nextI = clampWide(wideI);
      nextQ = clampWide(wideQ);
    end else begin
      nextI = roundSat(sumRe);
      nextQ = iqR ? roundSat(sumIm) : '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outI <= '0;
      outQ <= '0;
    end else begin
      outI <= nextI;
      outQ <= nextQ;
    end
  end

  // R4
  lut_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.phaseIdx == '0) |=> (cosR == FULL && sinR == '0));

  // R5
  real_q_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!dualR && !iqR) |=> (outQ == '0));

  // R7
  dual_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dualR && !flipR) |=> (outI == $past(iR) && outQ == $past(qR)));

  // R8
  dual_negate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dualR && flipR && iR != {1'b1, {(DW-1){1'b0}}}) |=> (outI == -$past(iR)));

endmodule

// File: rtl/nco_mixer.sv
`timescale 1ns/1ps
module nco_mixer
  import nco_mix_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [PHASE_W-1:0]         freqWord,
  input  logic                       phaseClr,
  input  logic [1:0]                 mixMode,
  input  logic signed [SAMPLE_W-1:0] sampleI,
  input  logic signed [SAMPLE_W-1:0] sampleQ,
  output logic signed [SAMPLE_W-1:0] outI,
  output logic signed [SAMPLE_W-1:0] outQ
);

  mixCtl_t ctl;

  nco_mix_ctrl #(.PW(PHASE_W), .AW(LUT_AW)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .freqWord (freqWord),
    .phaseClr (phaseClr),
    .mixMode  (mixMode),
    .ctl      (ctl)
  );

  nco_mix_datapath #(.DW(SAMPLE_W), .AW(LUT_AW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .sampleI (sampleI),
    .sampleQ (sampleQ),
    .outI    (outI),
    .outQ    (outQ)
  );

endmodule

// File: tb/sim_nco_mixer.sv
`timescale 1ns/1ps
module sim_nco_mixer;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [31:0]        freqWord = '0;
  logic               phaseClr = 1'b0;
  logic [1:0]         mixMode = 2'b00;
  logic signed [15:0] sampleI = '0;
  logic signed [15:0] sampleQ = '0;
  logic signed [15:0] outI;
  logic signed [15:0] outQ;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  nco_mixer u0 (
    .clk(clk), .rstN(rstN), .freqWord(freqWord), .phaseClr(phaseClr),
    .mixMode(mixMode), .sampleI(sampleI), .sampleQ(sampleQ),
    .outI(outI), .outQ(outQ)
  );

  typedef struct packed {
    logic [1:0]         mode;
    logic [31:0]        phase;
    logic signed [15:0] vi;
    logic signed [15:0] vq;
    logic signed [15:0] ei;
    logic signed [15:0] eq;
  } vec_t;

  // quarter-point phases: exact table values (R4), small operands (R5, R6)
  localparam vec_t VECS [10] = '{
    '{2'd0, 32'h0000_0000,  16'sd1000,   16'sd500,   16'sd1000,     16'sd0},
    '{2'd0, 32'h4000_0000,  16'sd1000,   16'sd500,  -16'sd500,      16'sd0},
    '{2'd0, 32'h8000_0000,  16'sd1000,   16'sd500,  -16'sd1000,     16'sd0},
    '{2'd0, 32'hC000_0000,  16'sd1000,   16'sd500,   16'sd500,      16'sd0},
    '{2'd1, 32'h0000_0000,  16'sd1200,  -16'sd700,   16'sd1200,    -16'sd700},
    '{2'd1, 32'h4000_0000,  16'sd1200,  -16'sd700,   16'sd700,      16'sd1200},
    '{2'd1, 32'h8000_0000,  16'sd1200,  -16'sd700,  -16'sd1200,     16'sd700},
    '{2'd1, 32'hC000_0000,  16'sd1200,  -16'sd700,  -16'sd700,     -16'sd1200},
    '{2'd3, 32'h0000_0000, -16'sd3000,   16'sd9,    -16'sd3000,     16'sd0},
    '{2'd1, 32'h0000_0000,  16'sd16384, -16'sd16384, 16'sd16384,   -16'sd16383}
  };

  task automatic check(input string req, input logic signed [15:0] act,
                       input logic signed [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // clear, load the wanted phase for one edge, hold, then read (R3, R9)
  task automatic runPhase(input logic [1:0] mode, input logic [31:0] ph,
                          input logic signed [15:0] vi, input logic signed [15:0] vq);
    @(negedge clk);
    mixMode = mode; sampleI = vi; sampleQ = vq;
    freqWord = ph; phaseClr = 1'b1;
    @(posedge clk);
    @(negedge clk); phaseClr = 1'b0;
    @(posedge clk);
    @(negedge clk); freqWord = '0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  // clear and then step freely with a fixed word; returns at the first read
  task automatic startRun(input logic [1:0] mode, input logic [31:0] fw,
                          input logic signed [15:0] vi, input logic signed [15:0] vq);
    @(negedge clk);
    mixMode = mode; sampleI = vi; sampleQ = vq;
    freqWord = fw; phaseClr = 1'b1;
    @(posedge clk);
    @(negedge clk); phaseClr = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    sampleI = 16'sd1234; sampleQ = 16'sd4321; freqWord = 32'h1234_5678;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 outI in reset", outI, 16'sd0);
    check("R1 outQ in reset", outQ, 16'sd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 outI first cycle", outI, 16'sd0);
    check("R1 outQ first cycle", outQ, 16'sd0);

    // vector table: R4 quadrant values through R5 and R6 mixing
    for (int v = 0; v < 10; v++) begin
      runPhase(VECS[v].mode, VECS[v].phase, VECS[v].vi, VECS[v].vq);
      check((VECS[v].mode == 2'd1) ? "R6 outI" : "R5 outI", outI, VECS[v].ei);
      check((VECS[v].mode == 2'd1) ? "R6 outQ" : "R5 outQ", outQ, VECS[v].eq);
    end

    // R2: positive step of a quarter turn, including wrap past 2^32
    startRun(2'd1, 32'h4000_0000, 16'sd1000, 16'sd0);
    check("R2 step0 I", outI, 16'sd1000);   check("R2 step0 Q", outQ, 16'sd0);
    @(negedge clk);
    check("R2 step1 I", outI, 16'sd0);      check("R2 step1 Q", outQ, 16'sd1000);
    @(negedge clk);
    check("R2 step2 I", outI, -16'sd1000);  check("R2 step2 Q", outQ, 16'sd0);
    @(negedge clk);
    check("R2 step3 I", outI, 16'sd0);      check("R2 step3 Q", outQ, -16'sd1000);
    @(negedge clk);
    check("R2 wrap I", outI, 16'sd1000);    check("R2 wrap Q", outQ, 16'sd0);

    // R2: negative frequency word
    startRun(2'd1, 32'hC000_0000, 16'sd1000, 16'sd0);
    check("R2 neg step0 Q", outQ, 16'sd0);
    @(negedge clk); check("R2 neg step1 Q", outQ, -16'sd1000);
    @(negedge clk); check("R2 neg step2 Q", outQ, 16'sd0);
    @(negedge clk); check("R2 neg step3 Q", outQ, 16'sd1000);

    // R8: saturation at one eighth of a turn
    runPhase(2'd1, 32'h2000_0000, 16'sd32767, -16'sd32768);
    check("R8 sat high I", outI, 16'sd32767);
    check("R8 round Q", outQ, -16'sd1);
    runPhase(2'd1, 32'h2000_0000, -16'sd32768, 16'sd32767);
    check("R8 sat low I", outI, -16'sd32768);
    check("R8 round Q low", outQ, -16'sd1);

    // R7: two real channels, freqWord ignored, alternating sign
    startRun(2'd2, 32'h1234_5679, -16'sd32768, 16'sd1234);
    check("R7 plus I", outI, -16'sd32768);  check("R7 plus Q", outQ, 16'sd1234);
    @(negedge clk);
    check("R8 negate full scale", outI, 16'sd32767);
    check("R7 minus Q", outQ, -16'sd1234);
    @(negedge clk);
    check("R7 plus again I", outI, -16'sd32768);
    check("R7 plus again Q", outQ, 16'sd1234);

    // R3: clear in mid-run restarts at phase 0
    startRun(2'd0, 32'h4000_0000, 16'sd777, 16'sd0);
    @(negedge clk); check("R3 running", outI, 16'sd0);
    startRun(2'd0, 32'h4000_0000, 16'sd777, 16'sd0);
    check("R3 restart I", outI, 16'sd777);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule